// File: doc/BRIEF.md
# Asymmetric-Delay Edge Detector

This block watches one single-bit input and finds its edges using two delay cells, each of which delays only one direction of change. The rise-lag cell lets a high through one clock cycle late but lets a low through in the same cycle. The fall-lag cell is the mirror image: it lets a low through one cycle late and a high through at once. The fall-lag cell is built as an inverter, then a rise-lag cell, then a second inverter. One clock cycle counts as one tick.

The rising-edge path compares the input with the rise-lag cell. Its output is an active-high strobe that lasts one tick for each low-to-high change. The falling-edge path compares the input with the fall-lag cell. Its output is an active-low strobe that rests high and drops for one tick for each high-to-low change. Both cell values are also brought out so that they can drive other logic. Only one register is needed: a copy of the input from the previous tick, which a synchronous reset clears to 0. The input is assumed to be synchronous to the clock already.

Top module: `edge_lag_detect`

## Requirements
- R1: While `rst` is high at a clock edge, the stored previous input is cleared to 0. On the first cycle after reset, `riseLag` is low, and a high `sigIn` is taken as a rising edge.
- R2: `riseLag` goes high in the second consecutive cycle that `sigIn` is high. In other words, it goes high one tick after the input goes high.
- R3: `riseLag` is low in any cycle where `sigIn` is low, including the cycle in which `sigIn` falls.
- R4: `fallLag` goes low only in the second consecutive cycle that `sigIn` is low.
- R5: `fallLag` is high in any cycle where `sigIn` is high, including the cycle in which `sigIn` rises.
- R6: `risePulse` (active high) is 1 for exactly one cycle: the first cycle that `sigIn` is high after a cycle where it was low. It is 0 in every other cycle.
- R7: `fallStrobeN` (active low) is 0 for exactly one cycle: the first cycle that `sigIn` is low after a cycle where it was high. It is 1 in every other cycle.
- R8: A high pulse on `sigIn` that lasts a single cycle gives a `risePulse` in that cycle and a `fallStrobeN` low in the next cycle, so neither edge is lost.
- R9: `risePulse` high and `fallStrobeN` low never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one rising edge is one tick |
| rst | input | 1 | Synchronous reset, active high |
| sigIn | input | 1 | Monitored input, already synchronous to `clk` |
| riseLag | output | 1 | Rise-lag cell output: a high arrives one tick late, a low arrives at once |
| fallLag | output | 1 | Fall-lag cell output: a low arrives one tick late, a high arrives at once |
| risePulse | output | 1 | One-tick active-high strobe on each rising edge of `sigIn` |
| fallStrobeN | output | 1 | One-tick active-low strobe on each falling edge of `sigIn`; rests high |

## Verification
Each output is combinational from `sigIn` and the single stored previous input. A change on `sigIn` therefore shows at once on `risePulse`, `fallStrobeN` and the undelayed direction of each cell, in the same cycle. The delayed direction of each cell shows up exactly one clock edge later. The bench drives `sigIn` on the falling clock edge and samples all four outputs 1 ns after that, which is well before the next rising edge. It updates its own previous-input record on each rising edge, so every comparison is made against the state the design holds in that cycle.

// File: rtl/edge_lag_pkg.sv
package edge_lag_pkg;

  // Previous-tick history that the control sends to the datapath.
  // prevHigh: the input was high on the previous tick.
  // prevLow:  the input was low on the previous tick.
  typedef struct packed {
    logic prevHigh;
    logic prevLow;
  } histStrobesT;

  // Number of asymmetric cells in the datapath: one rise-lag, one fall-lag.
  localparam int unsigned NUM_CELLS = 2;
  localparam int unsigned RISE_IDX  = 0;
  localparam int unsigned FALL_IDX  = 1;

endpackage

// File: rtl/lag_cell.sv
// Core one-direction delay: a high passes only when the cell's input was
// already high on the previous tick, and a low passes at once.
module lag_cell (
  input  logic curLevel,
  input  logic prevLevel,
  output logic lagOut
);
  always_comb lagOut = curLevel & prevLevel;
endmodule

// File: rtl/edge_lag_ctrl.sv
// Control: holds the single history register and sends it out as strobes.
module edge_lag_ctrl
  import edge_lag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sigIn,
  output histStrobesT hist
);
  logic prevIn;

  always_ff @(posedge clk) begin
    if (rst) prevIn <= 1'b0;
    else     prevIn <= sigIn;
  end

  always_comb begin
    hist.prevHigh = prevIn;
    hist.prevLow  = ~prevIn;
  end

  // R1: a reset edge leaves the history cleared
  p_hist_clear_r1: assert property (@(posedge clk)
    rst |=> (!hist.prevHigh && hist.prevLow));

  // the two strobes are always complementary
  p_hist_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot({hist.prevHigh, hist.prevLow}));

endmodule

// File: rtl/edge_lag_datapath.sv
// Datapath: the rise-lag cell, and the fall-lag cell made as
// inverter -> rise-lag cell -> inverter. Each edge detector compares
// the input with one of the two cells.
module edge_lag_datapath
  import edge_lag_pkg::*;
(
  input  logic        sigIn,
  input  histStrobesT hist,
  output logic        riseLag,
  output logic        fallLag,
  output logic        risePulse,
  output logic        fallStrobeN
);
  logic [NUM_CELLS-1:0] cellIn;
  logic [NUM_CELLS-1:0] cellPrev;
  logic [NUM_CELLS-1:0] cellRaw;
  logic [NUM_CELLS-1:0] cellOut;

  for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
    if (gi == FALL_IDX) begin : g_inv
      // Inverting wrapper: the inner cell sees the complemented input.
      always_comb begin
        cellIn[gi]   = ~sigIn;
        cellPrev[gi] = hist.prevLow;
        cellOut[gi]  = ~cellRaw[gi];
      end
    end else begin : g_direct
      always_comb begin
        cellIn[gi]   = sigIn;
        cellPrev[gi] = hist.prevHigh;
        cellOut[gi]  = cellRaw[gi];
      end
    end
    lag_cell u_cell (
      .curLevel (cellIn[gi]),
      .prevLevel(cellPrev[gi]),
      .lagOut   (cellRaw[gi])
    );
  end

  always_comb begin
    riseLag     = cellOut[RISE_IDX];
    fallLag     = cellOut[FALL_IDX];
    risePulse   = sigIn & ~riseLag;
    fallStrobeN = sigIn | ~fallLag;
  end

endmodule

// File: rtl/edge_lag_detect.sv
// Thin top: control (history register) plus datapath (cells and detectors).
module edge_lag_detect
  import edge_lag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sigIn,
  output logic riseLag,
  output logic fallLag,
  output logic risePulse,
  output logic fallStrobeN
);
  histStrobesT hist;

  edge_lag_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .sigIn(sigIn),
    .hist (hist)
  );

  edge_lag_datapath u_dp (
    .sigIn      (sigIn),
    .hist       (hist),
    .riseLag    (riseLag),
    .fallLag    (fallLag),
    .risePulse  (risePulse),
    .fallStrobeN(fallStrobeN)
  );

  // R2: the second high tick in a row shows a high on the rise-lag cell
  p_rise_lag_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sigIn) && sigIn) |-> riseLag);

  // R3: a low input pulls the rise-lag cell low in the same tick
  p_rise_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !sigIn |-> !riseLag);

  // R4: the second low tick in a row shows a low on the fall-lag cell
  p_fall_lag_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sigIn) && !sigIn) |-> !fallLag);

  // R5: a high input lifts the fall-lag cell in the same tick
  p_fall_up_r5: assert property (@(posedge clk) disable iff (rst)
    sigIn |-> fallLag);

  // R6: a rising strobe lasts one tick
  p_rise_once_r6: assert property (@(posedge clk) disable iff (rst)
    risePulse |=> !risePulse);

  // R7: a falling strobe lasts one tick
  p_fall_once_r7: assert property (@(posedge clk) disable iff (rst)
    !fallStrobeN |=> fallStrobeN);

  // R8: a one-tick input pulse is followed by a falling strobe
  p_pulse_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(risePulse) && !sigIn) |-> !fallStrobeN);

  // R9: the two strobes are never active together
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(risePulse && !fallStrobeN));

endmodule

// File: tb/tb_edge_lag_detect.sv
`timescale 1ns/1ps
module tb_edge_lag_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sigIn = 1'b0;
  logic riseLag, fallLag, risePulse, fallStrobeN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // behavioural history: queue of input levels seen at rising edges
  logic seenQ[$];
  int   edgeCount = 0;

  always #2.5 clk = ~clk;

  edge_lag_detect dut (
    .clk(clk), .rst(rst), .sigIn(sigIn),
    .riseLag(riseLag), .fallLag(fallLag),
    .risePulse(risePulse), .fallStrobeN(fallStrobeN)
  );

  always @(posedge clk) begin
    if (rst) seenQ.push_back(1'b0);
    else     seenQ.push_back(sigIn);
    if (seenQ.size() > 4) void'(seenQ.pop_front());
  end

  function automatic logic lastSeen();
    if (seenQ.size() == 0) return 1'b0;
    return seenQ[seenQ.size()-1];
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every output against the model for this cycle
  task automatic checkAll();
    logic prv;
    int inI;
    prv = lastSeen();
    inI = sigIn;
    // rise-lag: high only on a second high tick (R2), low when input low (R3)
    check(riseLag, (inI == 1 && prv == 1) ? 1'b1 : 1'b0, "R2/R3 riseLag");
    // fall-lag: low only on a second low tick (R4), high when input high (R5)
    check(fallLag, (inI == 0 && prv == 0) ? 1'b0 : 1'b1, "R4/R5 fallLag");
    // R6: rising strobe on first high tick
    check(risePulse, (inI == 1 && prv == 0) ? 1'b1 : 1'b0, "R6 risePulse");
    // R7: falling strobe on first low tick
    check(fallStrobeN, (inI == 0 && prv == 1) ? 1'b0 : 1'b1, "R7 fallStrobeN");
    // R9: strobes exclusive
    check(risePulse & ~fallStrobeN, 1'b0, "R9 strobe overlap");
  endtask

  task automatic tick(input logic v, input logic r);
    @(negedge clk);
    sigIn = v;
    rst = r;
    #1;
    checkAll();
  endtask

  initial begin
    // reset with input low
    repeat (3) tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    // R1: reset state with input low
    check(risePulse, 1'b0, "R1 risePulse after reset");
    check(fallStrobeN, 1'b1, "R1 fallStrobeN after reset");
    check(riseLag, 1'b0, "R1 riseLag after reset");

    // reset while input held high, then release: first tick is an edge
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    check(riseLag, 1'b0, "R1 riseLag cleared by reset");
    check(risePulse, 1'b1, "R1 edge from cleared history");
    tick(1'b1, 1'b0);
    check(riseLag, 1'b1, "R2 riseLag after one tick");

    // R3 and R7 on the falling tick
    tick(1'b0, 1'b0);
    check(riseLag, 1'b0, "R3 riseLag drops at once");
    check(fallLag, 1'b1, "R4 fallLag still high on first low tick");
    check(fallStrobeN, 1'b0, "R7 falling strobe");
    tick(1'b0, 1'b0);
    check(fallLag, 1'b0, "R4 fallLag low after one tick");
    check(fallStrobeN, 1'b1, "R7 strobe one tick only");
    tick(1'b1, 1'b0);
    check(fallLag, 1'b1, "R5 fallLag rises at once");

    // R8: single-tick high pulse
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    check(risePulse, 1'b1, "R8 rise strobe for one-tick pulse");
    tick(1'b0, 1'b0);
    check(fallStrobeN, 1'b0, "R8 fall strobe after one-tick pulse");
    check(risePulse, 1'b0, "R8 no rise strobe on low tick");

    // alternating pattern
    for (int i = 0; i < 40; i++) tick(logic'(i % 2), 1'b0);
    // long runs
    repeat (10) tick(1'b1, 1'b0);
    repeat (10) tick(1'b0, 1'b0);

    // random sequences, with an occasional reset
    for (int i = 0; i < 3000; i++) begin
      logic v;
      logic r;
      v = logic'($urandom_range(0, 1));
      r = ($urandom_range(0, 199) == 0) ? 1'b1 : 1'b0;
      tick(v, r);
      if (!r && v && !risePulse && fallStrobeN) edgeCount++;
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule